// File: doc/BRIEF.md
# UART receiver with error-tagged receive buffer

This block turns an asynchronous serial line into parallel characters and keeps them for a host. The line is synchronised into the clock domain and then examined sixteen times per bit period. A falling edge starts a frame candidate. The candidate becomes a frame only if the line is still low half a bit later. After that the receiver samples eight data bits at their centres, least significant bit first. It then samples an optional parity bit, which can be even or odd, and the first stop bit. It waits out the rest of a stop length of one, one and a half or two bit periods before it looks for the next frame.

Each finished character enters the receive buffer with three status bits: parity error, framing error and break. When `fifo_en` is low, the buffer holds a single character. When it is high, the buffer is a 16-entry first-in first-out store. A change of `fifo_en` empties the buffer. The host sees the oldest character and its status on the read port, removes it with a one-cycle `pop`, and gets an interrupt request while anything is waiting. A character that arrives while the buffer is full is dropped and sets a sticky overrun flag. The bit period is `baud_div` clock cycles times sixteen.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, `rd_valid`, `irq` and `overrun` are low and the buffer is in single-character mode, holding at most one character.
- R2: A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit and a high stop bit. The received byte appears on `rd_data` with `rd_valid` high.
- R3: With `par_en` high, `rd_pe` is set when the count of ones over the data and parity bits is odd (`par_odd`=0) or even (`par_odd`=1). With `par_en` low, `rd_pe` is never set.
- R4: `rd_fe` is set when the first stop bit is sampled low. `rd_brk` is set when the data bits, the parity bit (if enabled) and the first stop bit are all low. `rd_brk` never appears without `rd_fe`.
- R5: `stop_sel` selects the stop length: 0 gives one bit period, 1 gives one and a half, and 2 gives two. Frames that follow each other with no idle gap are all received.
- R6: A low pulse that has ended by the middle of the start bit is discarded and produces no character.
- R7: Characters are received correctly when each start, data, parity and stop pulse is anywhere from 0.96 to 1.05 of a bit period long.
- R8: A character that arrives while the buffer is full is discarded and sets `overrun`. `overrun` stays high until `ovr_clr` is pulsed. In single-character mode one `pop` empties the buffer.
- R9: With `fifo_en` high, the buffer holds 16 characters and delivers them in arrival order. A 17th character is discarded.
- R10: Any change of `fifo_en` empties the buffer by the next cycle.
- R11: `irq` is high exactly while the buffer holds at least one character. A character with error flags therefore also raises it.
- R12: After a frame with a low stop bit, the receiver waits for the line to return high before it accepts a new start bit. A long low line produces a single break character.
- R13: The bit period is 16 × `baud_div` clock cycles, and `baud_div` can be changed between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idle high |
| baud_div | input | DIV_W | Clock cycles per sixteenth of a bit |
| fifo_en | input | 1 | 0: one-character buffer, 1: 16-entry buffer |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| stop_sel | input | 2 | Stop length: 0 one bit, 1 one and a half, 2 two |
| pop | input | 1 | Remove the head character |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | DATA_W | Head character |
| rd_pe | output | 1 | Parity error on the head character |
| rd_fe | output | 1 | Framing error on the head character |
| rd_brk | output | 1 | Break on the head character |
| rd_valid | output | 1 | The buffer holds a character |
| overrun | output | 1 | Sticky: a character was discarded |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is a character whose pulse widths sit at both edges of the tolerance band within one frame. Uniform stretching does not reach it, because drift over a frame hides the per-pulse limit. The bench alternates pulses of 0.96 and 1.05 bit periods across start, data, parity and stop, in both phase orders.

The full-buffer discard is reached only after sixteen unread frames have been sent with no idle gap. A break needs a line held low well past a frame length. Both are driven directly by serial tasks that shape every pulse in nanoseconds, away from the clock grid.

// File: rtl/uart_rx_buf.sv
`timescale 1ns/1ps
module uart_rx_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              fifo_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop_sel,
  input  logic              pop,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pe,
  output logic              rd_fe,
  output logic              rd_brk,
  output logic              rd_valid,
  output logic              overrun,
  output logic              irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int EW = DATA_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_EXTRA, S_WAITHI} st_t;

  logic [1:0]        sync;
  logic [DIV_W-1:0]  divcnt;
  st_t               st;
  logic [3:0]        os;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic [EW-1:0]     mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              mode_q;

  wire              rx       = sync[1];
  wire [DIV_W-1:0]  div_last = (baud_div == '0) ? '0 : baud_div - 1'b1;
  wire              tick     = divcnt >= div_last;
  wire [3:0]        ext_last = (stop_sel == 2'd1) ? 4'd7 : 4'd15;
  wire              push_req = tick && st == S_STOP && os == 4'd15;
  wire              new_pe   = par_en & (^shreg ^ pbit ^ par_odd);
  wire              new_fe   = !rx;
  wire              new_brk  = !rx && shreg == '0 && !(par_en && pbit);
  wire [CW-1:0]     limit    = mode_q ? CW'(DEPTH) : CW'(1);
  wire              full     = cnt >= limit;
  wire              push_ok  = push_req && !full;
  wire              do_pop   = pop && cnt != '0;
  wire              mode_chg = fifo_en != mode_q;
  wire [EW-1:0]     head     = mem[rp];

  assign rd_valid = cnt != '0;
  assign rd_data  = head[DATA_W-1:0];
  assign rd_pe    = rd_valid & head[DATA_W];
  assign rd_fe    = rd_valid & head[DATA_W+1];
  assign rd_brk   = rd_valid & head[DATA_W+2];
  assign irq      = rd_valid;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync   <= 2'b11;
      divcnt <= '0;
    end else begin
      sync   <= {sync[0], rxd};
      divcnt <= tick ? '0 : divcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      os    <= '0;
      bitn  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (tick) begin
      case (st)
        S_IDLE: if (!rx) begin st <= S_START; os <= '0; end
        S_START:
          if (os == 4'd7) begin
            os   <= '0;
            bitn <= '0;
            st   <= rx ? S_IDLE : S_DATA;
          end else os <= os + 1'b1;
        S_DATA:
          if (os == 4'd15) begin
            os    <= '0;
            shreg <= {rx, shreg[DATA_W-1:1]};
            if (bitn == BW'(DATA_W-1)) st <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end else os <= os + 1'b1;
        S_PAR:
          if (os == 4'd15) begin
            os   <= '0;
            pbit <= rx;
            st   <= S_STOP;
          end else os <= os + 1'b1;
        S_STOP:
          if (os == 4'd15) begin
            os <= '0;
            if (!rx)                  st <= S_WAITHI;
            else if (stop_sel == 2'd0) st <= S_IDLE;
            else                      st <= S_EXTRA;
          end else os <= os + 1'b1;
        S_EXTRA:
          if (os == ext_last) begin os <= '0; st <= S_IDLE; end
          else os <= os + 1'b1;
        S_WAITHI: if (rx) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      mode_q  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      if (mode_chg) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push_ok) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        cnt <= cnt + CW'(push_ok) - CW'(do_pop);
      end
      if (push_req && full) overrun <= 1'b1;
      else if (ovr_clr)     overrun <= 1'b0;
    end

  always_ff @(posedge clk)
    if (push_ok && !mode_chg) mem[wp] <= {new_brk, new_fe, new_pe, shreg};

endmodule

module uart_rx_buf_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pop,
  input logic          ovr_clr,
  input logic          fifo_en,
  input logic          rd_valid,
  input logic          rd_fe,
  input logic          rd_brk,
  input logic          overrun,
  input logic          push_req,
  input logic          full,
  input logic          mode_q,
  input logic [CW-1:0] cnt
);
  assert_brk_implies_fe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_brk |-> rd_fe);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(push_req && full));

  assert_single_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && pop && !fifo_en && !push_req |=> !rd_valid);

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (mode_q ? CW'(DEPTH) : CW'(1)));

  assert_mode_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en != mode_q |=> !rd_valid);

  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(push_req));
endmodule

bind uart_rx_buf uart_rx_buf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pop(pop), .ovr_clr(ovr_clr), .fifo_en(fifo_en),
  .rd_valid(rd_valid), .rd_fe(rd_fe), .rd_brk(rd_brk), .overrun(overrun),
  .push_req(push_req), .full(full), .mode_q(mode_q), .cnt(cnt)
);

// File: tb/test_uart_rx_buf.sv
`timescale 1ns/1ps
module test_uart_rx_buf;
  logic        clk = 0, rst_n = 0, rxd = 1;
  logic [15:0] baud_div = 16'd4;
  logic        fifo_en = 0, par_en = 0, par_odd = 0, pop = 0, ovr_clr = 0;
  logic [1:0]  stop_sel = 0;
  logic [7:0]  rd_data;
  logic        rd_pe, rd_fe, rd_brk, rd_valid, overrun, irq;
  int n_chk = 0, n_fail = 0, bit_ns = 320;

  always #2.5 clk = ~clk;

  uart_rx_buf i_uart_rx_buf (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(baud_div), .fifo_en(fifo_en),
    .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel), .pop(pop), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .rd_pe(rd_pe), .rd_fe(rd_fe), .rd_brk(rd_brk),
    .rd_valid(rd_valid), .overrun(overrun), .irq(irq)
  );

  // [15:8] data, [7] parity on, [6] odd, [5:4] stop_sel, [3] corrupt parity, [2] stop low
  localparam logic [15:0] VEC [10] = '{
    {8'hA5, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'h3C, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 2'b00},
    {8'h3D, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 2'b00},
    {8'h81, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 2'b00},
    {8'h7E, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 2'b00},
    {8'h55, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'b00},
    {8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'b00},
    {8'h00, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'b00},
    {8'h00, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 2'b00},
    {8'hFF, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                            input logic flip, input logic stoplow, input int halves,
                            input int wa, input int wb);
    int k;
    k = 0;
    rxd = 0; #(((k % 2) == 0) ? wa : wb); k++;
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; #(((k % 2) == 0) ? wa : wb); k++;
    end
    if (pen) begin
      rxd = ^d ^ podd ^ flip; #(((k % 2) == 0) ? wa : wb); k++;
    end
    if (stoplow) begin
      rxd = 0; #(bit_ns);
      rxd = 1; #(bit_ns);
    end else begin
      rxd = 1; #(((k % 2) == 0) ? wa : wb);
      if (halves > 2) #((halves - 2) * bit_ns / 2);
    end
    rxd = 1;
  endtask

  task automatic send(input logic [7:0] d);
    send_frame(d, par_en, par_odd, 1'b0, 1'b0, 2 + int'(stop_sel), bit_ns, bit_ns);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1;
    @(negedge clk) pop = 0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk) fifo_en = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic pen, podd, flip, sl, pb;
    repeat (10) @(negedge clk);
    check("R1 valid in reset", rd_valid, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 valid", rd_valid, 0);
    check("R1 irq", irq, 0);
    check("R1 overrun", overrun, 0);

    for (int v = 0; v < 10; v++) begin
      d = VEC[v][15:8]; pen = VEC[v][7]; podd = VEC[v][6];
      flip = VEC[v][3]; sl = VEC[v][2];
      pb = ^d ^ podd ^ flip;
      @(negedge clk);
      par_en = pen; par_odd = podd; stop_sel = VEC[v][5:4];
      send_frame(d, pen, podd, flip, sl, 2 + int'(VEC[v][5:4]), bit_ns, bit_ns);
      settle();
      check("R2 valid", rd_valid, 1);
      check("R11 irq set", irq, 1);
      check("R2 data", rd_data, d);
      check("R3 parity flag", rd_pe, pen & flip);
      check("R4 framing flag", rd_fe, sl);
      check("R4 break flag", rd_brk, sl && d == 0 && (!pen || !pb));
      do_pop();
      check("R11 irq clear", irq, 0);
    end

    // R1: single-character mode out of reset -> second char overruns
    par_en = 0; stop_sel = 0;
    send(8'h11); send(8'h22); settle();
    check("R1 R8 head kept", rd_data, 8'h11);
    check("R8 overrun set", overrun, 1);
    repeat (200) @(negedge clk);
    check("R8 overrun sticky", overrun, 1);
    do_pop();
    check("R8 single pop empties", rd_valid, 0);
    @(negedge clk) ovr_clr = 1;
    @(negedge clk) ovr_clr = 0;
    check("R8 overrun cleared", overrun, 0);

    // R5: back-to-back frames for each stop length
    set_mode(1);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk) stop_sel = 2'(s); par_en = 1; par_odd = 1;
      send(8'h90 + 8'(s)); send(8'hA0 + 8'(s)); send(8'hB0 + 8'(s));
      settle();
      for (int j = 0; j < 3; j++) begin
        check("R5 back-to-back data", rd_data, 8'h90 + 8'(16 * j) + 8'(s));
        check("R5 no parity error", rd_pe, 0);
        do_pop();
      end
      check("R5 drained", rd_valid, 0);
    end

    // R7: pulse widths alternating at both ends of the tolerance band
    @(negedge clk) stop_sel = 2; par_en = 1; par_odd = 0;
    send_frame(8'h6B, 1, 0, 0, 0, 4, 307, 336);
    send_frame(8'hD4, 1, 0, 0, 0, 4, 336, 307);
    @(negedge clk) par_en = 0; stop_sel = 0;
    send_frame(8'hC3, 0, 0, 0, 0, 2, 307, 336);
    settle();
    check("R7 short/long", rd_data, 8'h6B); check("R7 pe", rd_pe, 0); do_pop();
    check("R7 long/short", rd_data, 8'hD4); check("R7 fe", rd_fe, 0); do_pop();
    check("R7 no parity", rd_data, 8'hC3); do_pop();

    // R6: glitch shorter than half a bit
    rxd = 0; #90; rxd = 1; #(3 * bit_ns);
    settle();
    check("R6 glitch ignored", rd_valid, 0);
    send(8'h5A); settle();
    check("R6 frame after glitch", rd_data, 8'h5A);
    do_pop();

    // R9: sixteen entries in order, seventeenth discarded
    for (int i = 0; i < 16; i++) send(8'h40 + 8'(i));
    settle();
    check("R9 no overrun at 16", overrun, 0);
    send(8'hEE); settle();
    check("R9 overrun on 17th", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      check("R9 order", rd_data, 8'h40 + 8'(i));
      do_pop();
    end
    check("R9 17th discarded", rd_valid, 0);
    @(negedge clk) ovr_clr = 1;
    @(negedge clk) ovr_clr = 0;

    // R10: mode change flushes
    send(8'h01); send(8'h02); settle();
    check("R10 filled", rd_valid, 1);
    set_mode(0);
    check("R10 flushed to single", rd_valid, 0);
    send(8'h03); settle();
    set_mode(1);
    check("R10 flushed to fifo", rd_valid, 0);

    // R12: long low line gives one break
    rxd = 0; #(40 * bit_ns); rxd = 1; #(2 * bit_ns);
    settle();
    check("R12 break char", rd_brk, 1);
    check("R12 framing", rd_fe, 1);
    do_pop();
    check("R12 single char", rd_valid, 0);
    check("R12 no overrun", overrun, 0);

    // R13: divisor halves the bit period
    @(negedge clk) baud_div = 16'd2; bit_ns = 160;
    repeat (20) @(negedge clk);
    send(8'h96); settle();
    check("R13 fast rate data", rd_data, 8'h96);
    check("R13 fast rate fe", rd_fe, 0);
    do_pop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule